// File: doc/BRIEF.md
# Serial Command Front End for a Dual Digital Potentiometer

This block is the serial slave that sits in front of a two-channel digitally controlled resistor. A host selects it by pulling `cs_n` low, then clocks in bits on SI that are sampled on rising SCK. Reply bits are driven on falling SCK. Every frame starts with an identification byte that carries a fixed device-type nibble and a two-bit bus address. Next comes an instruction byte, which holds a four-bit opcode, a data-slot select and a channel select. Some commands then take a third byte, which is either a data value or a reply. Each channel has a 6-bit volatile wiper code, which leaves the block as a switch-select code, and four 6-bit slots that are modelled as non-volatile.

The host can read and write the wiper and the slots. It can copy between a slot and the wiper, either on one channel or on both channels at once, and it can read a busy flag. There is also an open-ended stepping mode that nudges the wiper once per SCK pulse. Every change to a slot is held back until chip select rises after a complete frame. A slot change is refused while the write-protect input is low, and also while an earlier commit is still counting down. The commit time is a parameter given in system clock cycles. A HOLD input pauses a frame without losing its place.

All serial pins are oversampled by the system clock `clk`. SCK must therefore stay high and low for several `clk` periods.

Top module: `digipot_spi`

## Requirements
- R1: After reset, each channel's wiper code and its slot 0 both equal that channel's boot parameter, and slots 1 to 3 read zero.
- R2: The first byte after a falling `cs_n` must be 0101 in bits 7:4, 00 in bits 3:2 and `dev_addr` in bits 1:0. Any other value makes the rest of the frame change nothing and drive no reply.
- R3: The second byte holds the opcode in bits 7:4, the slot in bits 3:2, a required 0 in bit 1 and the channel in bit 0. The opcodes are 1001 read wiper, 1010 write wiper, 1011 read slot, 1100 write slot, 1101 slot to wiper, 1110 wiper to slot, 0001 slot to wiper on both channels, 1000 wiper to slot on both channels, 0010 stepping and 0101 read status. Any other opcode, or bit 1 set, makes the frame change nothing.
- R4: A data or reply byte is 00 followed by the 6-bit code, MSB first. SI is sampled on rising SCK and SO changes on falling SCK. A write-wiper takes effect once its data byte is complete.
- R5: A write-slot is applied only when `cs_n` rises after all 24 bits. A frame that ends early changes no register.
- R6: The status reply is 0000000 followed by the busy bit. The busy bit is 1 for NV_CYCLES clock cycles after a slot commit. A slot-changing command that completes while the busy bit is 1 is dropped.
- R7: While `wp_n` is low, write-slot, wiper-to-slot and both-channel wiper-to-slot commands change no slot.
- R8: A single-channel slot-to-wiper copy and a wiper-to-slot copy act on the addressed channel and slot when `cs_n` rises after the 16-bit frame.
- R9: The both-channel copies move data between each channel's wiper and the same slot on both channels at once.
- R10: In stepping mode, every SCK pulse after the instruction byte moves the selected wiper one code up when SI is 1 and one code down when SI is 0. The code saturates at 63 and 0, and the mode lasts until `cs_n` rises.
- R11: Taking `hold_n` low while SCK is low freezes the frame and turns off `so_oe`, and SCK edges during the pause are ignored. Releasing `hold_n` while SCK is low resumes the frame where it stopped.
- R12: `so_oe` is 0 while `cs_n` is high. After reset, no frame is accepted until `cs_n` has had a falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset, taken as power-up |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| hold_n | input | 1 | Pause request, active low |
| wp_n | input | 1 | Write protect for the slots, active low |
| dev_addr | input | 2 | Bus address strap compared with the identification byte |
| so | output | 1 | Serial reply data, valid while `so_oe` is 1 |
| so_oe | output | 1 | Output enable for the SO pad; 0 means high impedance |
| wiper_pos | output | 12 | Wiper codes, channel 0 in bits 5:0 and channel 1 in bits 11:6 |

## Verification
The parser is driven with good and bad identification bytes: wrong address, wrong type nibble, and non-zero reserved bits. This separates address gating from opcode decoding. Frames are cut short at 20 bits and compared with full-length frames, which shows that commits depend on a complete frame and not on the instruction alone. Back-to-back slot writes separate the busy lockout from write protection, since each one leaves a different slot value to read back. Stepping runs drive the code into both rails. HOLD pauses placed inside the instruction byte and inside a reply byte show whether the bit position survives the pause.

// File: rtl/digipot_pkg.sv
package digipot_pkg;

    localparam int CODE_W   = 6;
    localparam int NUM_POT  = 2;
    localparam int NUM_SLOT = 4;
    localparam int SLOT_W   = $clog2(NUM_SLOT);
    localparam int BYTE_W   = 8;
    localparam int CNT_W    = $clog2(BYTE_W);

    localparam logic [3:0]        DEV_TYPE = 4'b0101;
    localparam logic [CODE_W-1:0] CODE_TOP = '1;
    localparam logic [CODE_W-1:0] CODE_ONE = CODE_W'(1);

    typedef enum logic [3:0] {
        OP_BOTH_TO_WIPER = 4'b0001,
        OP_STEP          = 4'b0010,
        OP_STATUS        = 4'b0101,
        OP_BOTH_TO_SLOT  = 4'b1000,
        OP_RD_WIPER      = 4'b1001,
        OP_WR_WIPER      = 4'b1010,
        OP_RD_SLOT       = 4'b1011,
        OP_WR_SLOT       = 4'b1100,
        OP_SLOT_TO_WIPER = 4'b1101,
        OP_WIPER_TO_SLOT = 4'b1110
    } opcode_e;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_SET_WIPER,
        ACT_STEP,
        ACT_COPY_IN,
        ACT_COPY_OUT,
        ACT_BOTH_IN,
        ACT_BOTH_OUT,
        ACT_SET_SLOT
    } act_kind_e;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_ID,
        PS_INSTR,
        PS_DATA,
        PS_STEP,
        PS_DONE,
        PS_SKIP
    } parse_st_e;

    typedef struct packed {
        act_kind_e         kind;
        logic              pot;
        logic [SLOT_W-1:0] slot;
        logic [CODE_W-1:0] code;
        logic              up;
    } action_t;

    typedef struct packed {
        logic sck_rise;
        logic sck_fall;
        logic cs_fall;
        logic cs_rise;
        logic cs_high;
        logic si;
        logic paused;
        logic wp_ok;
    } pin_ev_t;

    localparam action_t NO_ACT = '{kind: ACT_NONE, pot: 1'b0, slot: '0, code: '0, up: 1'b0};

    function automatic logic op_known(input logic [3:0] op);
        case (op)
            OP_BOTH_TO_WIPER, OP_STEP, OP_STATUS, OP_BOTH_TO_SLOT, OP_RD_WIPER,
            OP_WR_WIPER, OP_RD_SLOT, OP_WR_SLOT, OP_SLOT_TO_WIPER,
            OP_WIPER_TO_SLOT: return 1'b1;
            default:          return 1'b0;
        endcase
    endfunction

    function automatic act_kind_e deferred_kind(input logic [3:0] op);
        case (op)
            OP_WR_SLOT:       return ACT_SET_SLOT;
            OP_SLOT_TO_WIPER: return ACT_COPY_IN;
            OP_WIPER_TO_SLOT: return ACT_COPY_OUT;
            OP_BOTH_TO_WIPER: return ACT_BOTH_IN;
            OP_BOTH_TO_SLOT:  return ACT_BOTH_OUT;
            default:          return ACT_NONE;
        endcase
    endfunction

    function automatic logic is_nv_kind(input act_kind_e k);
        return (k == ACT_SET_SLOT) || (k == ACT_COPY_OUT) || (k == ACT_BOTH_OUT);
    endfunction

    function automatic logic [CODE_W-1:0] step_code(input logic [CODE_W-1:0] c, input logic up);
        if (up)
            return (c == CODE_TOP) ? c : c + CODE_ONE;
        return (c == '0) ? c : c - CODE_ONE;
    endfunction

endpackage

// File: rtl/digipot_pins.sv
module digipot_pins
    import digipot_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_n,
    input  logic    sck,
    input  logic    si,
    input  logic    hold_n,
    input  logic    wp_n,
    output pin_ev_t ev
);

    logic sck_r, sck_q, cs_r, cs_q, si_r, hold_r, wp_r, paused;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_r  <= 1'b0;
            sck_q  <= 1'b0;
            cs_r   <= 1'b0;
            cs_q   <= 1'b0;
            si_r   <= 1'b0;
            hold_r <= 1'b1;
            wp_r   <= 1'b1;
            paused <= 1'b0;
        end else begin
            sck_r  <= sck;
            sck_q  <= sck_r;
            cs_r   <= cs_n;
            cs_q   <= cs_r;
            si_r   <= si;
            hold_r <= hold_n;
            wp_r   <= wp_n;
            if (cs_r)
                paused <= 1'b0;
            else if (!sck_r)
                paused <= !hold_r;
        end
    end

    always_comb begin
        ev.sck_rise = sck_r && !sck_q && !paused && !cs_r;
        ev.sck_fall = !sck_r && sck_q && !paused && !cs_r;
        ev.cs_fall  = !cs_r && cs_q;
        ev.cs_rise  = cs_r && !cs_q;
        ev.cs_high  = cs_r;
        ev.si       = si_r;
        ev.paused   = paused;
        ev.wp_ok    = wp_r;
    end

endmodule

// File: rtl/digipot_parser.sv
module digipot_parser
    import digipot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pin_ev_t           ev,
    input  logic [1:0]        dev_addr,
    input  logic [CODE_W-1:0] rd_wiper,
    input  logic [CODE_W-1:0] rd_slot,
    input  logic              busy,
    output logic              qry_pot,
    output logic [SLOT_W-1:0] qry_slot,
    output action_t           act,
    output logic              active,
    output logic              so_bit
);

    parse_st_e         state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg, tx, nxt;
    logic [3:0]        op_q;
    logic              pot_q;
    logic [SLOT_W-1:0] slot_q;
    logic [CODE_W-1:0] data_q;
    logic              byte_end;

    assign nxt      = {shreg[BYTE_W-2:0], ev.si};
    assign byte_end = (bit_cnt == CNT_W'(BYTE_W - 1));
    assign qry_pot  = nxt[0];
    assign qry_slot = nxt[3:2];
    assign active   = (state != PS_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= PS_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            tx      <= '0;
            so_bit  <= 1'b0;
            op_q    <= 4'b0000;
            pot_q   <= 1'b0;
            slot_q  <= '0;
            data_q  <= '0;
            act     <= NO_ACT;
        end else begin
            act <= NO_ACT;
            if (ev.cs_rise) begin
                state <= PS_IDLE;
                if (state == PS_DONE && deferred_kind(op_q) != ACT_NONE)
                    act <= '{kind: deferred_kind(op_q), pot: pot_q, slot: slot_q, code: data_q, up: 1'b0};
            end else if (ev.cs_fall) begin
                state   <= PS_ID;
                bit_cnt <= '0;
                so_bit  <= 1'b0;
            end else if (ev.sck_rise) begin
                case (state)
                    PS_ID, PS_INSTR, PS_DATA: begin
                        shreg   <= nxt;
                        bit_cnt <= bit_cnt + CNT_W'(1);
                        if (byte_end) begin
                            case (state)
                                PS_ID: begin
                                    if (nxt[7:4] == DEV_TYPE && nxt[3:2] == 2'b00 && nxt[1:0] == dev_addr)
                                        state <= PS_INSTR;
                                    else
                                        state <= PS_SKIP;
                                end
                                PS_INSTR: begin
                                    op_q   <= nxt[7:4];
                                    pot_q  <= nxt[0];
                                    slot_q <= nxt[3:2];
                                    if (nxt[1] || !op_known(nxt[7:4])) begin
                                        state <= PS_SKIP;
                                    end else begin
                                        case (nxt[7:4])
                                            OP_RD_WIPER: begin
                                                tx    <= {2'b00, rd_wiper};
                                                state <= PS_DATA;
                                            end
                                            OP_RD_SLOT: begin
                                                tx    <= {2'b00, rd_slot};
                                                state <= PS_DATA;
                                            end
                                            OP_STATUS: begin
                                                tx    <= {7'b0000000, busy};
                                                state <= PS_DATA;
                                            end
                                            OP_WR_WIPER, OP_WR_SLOT: begin
                                                tx    <= '0;
                                                state <= PS_DATA;
                                            end
                                            OP_STEP: state <= PS_STEP;
                                            default: state <= PS_DONE;
                                        endcase
                                    end
                                end
                                default: begin
                                    data_q <= nxt[CODE_W-1:0];
                                    state  <= PS_DONE;
                                    if (op_q == OP_WR_WIPER)
                                        act <= '{kind: ACT_SET_WIPER, pot: pot_q, slot: slot_q,
                                                 code: nxt[CODE_W-1:0], up: 1'b0};
                                end
                            endcase
                        end
                    end
                    PS_STEP: act <= '{kind: ACT_STEP, pot: pot_q, slot: slot_q, code: '0, up: ev.si};
                    default: ;
                endcase
            end else if (ev.sck_fall && state == PS_DATA) begin
                so_bit <= tx[BYTE_W-1];
                tx     <= {tx[BYTE_W-2:0], 1'b0};
            end
        end
    end

    a_r2_skip_is_silent: assert property (@(posedge clk) disable iff (rst)
        (state == PS_SKIP) |=> (act.kind == ACT_NONE));

    a_r11_pause_freezes_frame: assert property (@(posedge clk) disable iff (rst)
        (ev.paused && !ev.cs_high) |=> ($stable(state) && $stable(bit_cnt)));

endmodule

// File: rtl/digipot_channel.sv
module digipot_channel
    import digipot_pkg::*;
#(
    parameter int                IDX  = 0,
    parameter logic [CODE_W-1:0] BOOT = '0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  action_t                    act,
    input  logic                       nv_ok,
    input  logic [SLOT_W-1:0]          qry_slot,
    output logic [CODE_W-1:0]          wiper,
    output logic [CODE_W-1:0]          slot_pick,
    output logic [NUM_SLOT*CODE_W-1:0] slot_flat
);

    localparam logic MY_POT = 1'(IDX);

    logic [CODE_W-1:0] slots [NUM_SLOT];
    logic              hit;

    assign hit       = (act.pot == MY_POT);
    assign slot_pick = slots[qry_slot];

    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_flat
        assign slot_flat[s*CODE_W +: CODE_W] = slots[s];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wiper <= BOOT;
            for (int s = 0; s < NUM_SLOT; s++)
                slots[s] <= (s == 0) ? BOOT : '0;
        end else begin
            case (act.kind)
                ACT_SET_WIPER: if (hit) wiper <= act.code;
                ACT_STEP:      if (hit) wiper <= step_code(wiper, act.up);
                ACT_COPY_IN:   if (hit) wiper <= slots[act.slot];
                ACT_BOTH_IN:   wiper <= slots[act.slot];
                ACT_COPY_OUT:  if (hit && nv_ok) slots[act.slot] <= wiper;
                ACT_BOTH_OUT:  if (nv_ok) slots[act.slot] <= wiper;
                ACT_SET_SLOT:  if (hit && nv_ok) slots[act.slot] <= act.code;
                default: ;
            endcase
        end
    end

    a_r10_step_holds_top: assert property (@(posedge clk) disable iff (rst)
        (act.kind == ACT_STEP && hit && act.up && wiper == CODE_TOP) |=> (wiper == CODE_TOP));

    a_r10_step_holds_bottom: assert property (@(posedge clk) disable iff (rst)
        (act.kind == ACT_STEP && hit && !act.up && wiper == '0) |=> (wiper == '0));

    a_r1_boot_from_slot0: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (wiper == slots[0]));

endmodule

// File: rtl/digipot_nvtimer.sv
module digipot_nvtimer #(
    parameter int NV_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);

    localparam int TW = $clog2(NV_CYCLES + 1);

    logic [TW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (start)
            remain <= TW'(NV_CYCLES);
        else if (remain != '0)
            remain <= remain - TW'(1);
    end

    assign busy = (remain != '0);

    a_r6_busy_after_commit: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

endmodule

// File: rtl/digipot_spi.sv
module digipot_spi
    import digipot_pkg::*;
#(
    parameter int                NV_CYCLES  = 1000,
    parameter logic [CODE_W-1:0] BOOT_CODE0 = 6'd32,
    parameter logic [CODE_W-1:0] BOOT_CODE1 = 6'd32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cs_n,
    input  logic                      sck,
    input  logic                      si,
    input  logic                      hold_n,
    input  logic                      wp_n,
    input  logic [1:0]                dev_addr,
    output logic                      so,
    output logic                      so_oe,
    output logic [NUM_POT*CODE_W-1:0] wiper_pos
);

    pin_ev_t           ev;
    action_t           act;
    logic              active, so_bit, busy, nv_ok, nv_start, qry_pot, cs_high_w;
    logic [SLOT_W-1:0] qry_slot;

    logic [NUM_POT-1:0][CODE_W-1:0]          wipers, picks;
    logic [NUM_POT-1:0][NUM_SLOT*CODE_W-1:0] slot_all;

    digipot_pins u_pins (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
        .hold_n(hold_n), .wp_n(wp_n), .ev(ev)
    );

    digipot_parser u_parser (
        .clk(clk), .rst(rst), .ev(ev), .dev_addr(dev_addr),
        .rd_wiper(wipers[qry_pot]), .rd_slot(picks[qry_pot]), .busy(busy),
        .qry_pot(qry_pot), .qry_slot(qry_slot), .act(act),
        .active(active), .so_bit(so_bit)
    );

    assign nv_ok    = ev.wp_ok && !busy;
    assign nv_start = nv_ok && is_nv_kind(act.kind);

    digipot_nvtimer #(.NV_CYCLES(NV_CYCLES)) u_nvtimer (
        .clk(clk), .rst(rst), .start(nv_start), .busy(busy)
    );

    for (genvar p = 0; p < NUM_POT; p++) begin : g_ch
        digipot_channel #(
            .IDX (p),
            .BOOT((p == 0) ? BOOT_CODE0 : BOOT_CODE1)
        ) u_ch (
            .clk(clk), .rst(rst), .act(act), .nv_ok(nv_ok), .qry_slot(qry_slot),
            .wiper(wipers[p]), .slot_pick(picks[p]), .slot_flat(slot_all[p])
        );
        assign wiper_pos[p*CODE_W +: CODE_W] = wipers[p];
    end

    assign so_oe     = active && !ev.paused && !ev.cs_high;
    assign so        = so_oe && so_bit;
    assign cs_high_w = ev.cs_high;

    a_r7_protect_blocks_slots: assert property (@(posedge clk) disable iff (rst)
        (is_nv_kind(act.kind) && !ev.wp_ok) |=> $stable(slot_all));

    a_r6_busy_blocks_slots: assert property (@(posedge clk) disable iff (rst)
        (is_nv_kind(act.kind) && busy) |=> $stable(slot_all));

    a_r12_float_when_deselected: assert property (@(posedge clk) disable iff (rst)
        (cs_high_w && $past(cs_high_w)) |-> !so_oe);

endmodule

// File: tb/digipot_spi_bench.sv
module digipot_spi_bench;
    import digipot_pkg::*;

    localparam int         NV  = 600;
    localparam logic [5:0] B0  = 6'd20;
    localparam logic [5:0] B1  = 6'd40;
    localparam logic [1:0] ADR = 2'b10;

    logic        clk = 1'b0, rst = 1'b1, cs_n = 1'b0, sck = 1'b0, si = 1'b0;
    logic        hold_n = 1'b1, wp_n = 1'b1;
    logic [1:0]  dev_addr = ADR;
    logic        so, so_oe;
    logic [11:0] wiper_pos;

    always #4 clk = ~clk;

    digipot_spi #(.NV_CYCLES(NV), .BOOT_CODE0(B0), .BOOT_CODE1(B1)) u_digipot_spi (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
        .wp_n(wp_n), .dev_addr(dev_addr), .so(so), .so_oe(so_oe), .wiper_pos(wiper_pos)
    );

    int         checks = 0, errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] got_q[$];

    task automatic chk(input string req, input logic [31:0] actual, input logic [31:0] expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, actual, expected);
        end
    endtask

    // scoreboard monitor: pairs captured replies with expected ones
    always @(negedge clk) begin
        while (got_q.size() > 0) begin
            if (exp_q.size() == 0) begin
                chk("unexpected reply", {24'd0, got_q.pop_front()}, 32'hFFFF_FFFF);
            end else begin
                chk(tag_q.pop_front(), {24'd0, got_q.pop_front()}, {24'd0, exp_q.pop_front()});
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic spi_bit(input logic b, output logic r);
        si = b;
        tick(4);
        sck = 1'b1;
        tick(3);
        r = so;
        tick(1);
        sck = 1'b0;
    endtask

    task automatic do_hold();
        logic unused;
        hold_n = 1'b0;
        tick(4);
        chk("R11 so_oe off in pause", {31'd0, so_oe}, 32'd0);
        for (int k = 0; k < 2; k++) begin
            si = 1'b1;
            sck = 1'b1;
            tick(4);
            sck = 1'b0;
            tick(4);
        end
        unused = so;
        hold_n = 1'b1;
        tick(4);
    endtask

    task automatic frame(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                         input int nbits, input int hold_at, output logic [7:0] rx);
        logic [23:0] v;
        logic        r;
        v  = {b0, b1, b2};
        rx = '0;
        cs_n = 1'b0;
        tick(4);
        for (int i = 0; i < nbits; i++) begin
            if (i == hold_at) do_hold();
            spi_bit(v[23-i], r);
            if (i >= 16) rx = {rx[6:0], r};
        end
        tick(4);
        cs_n = 1'b1;
        tick(6);
    endtask

    function automatic logic [7:0] idb(input logic [1:0] a);
        return {4'b0101, 2'b00, a};
    endfunction

    function automatic logic [7:0] ins(input logic [3:0] op, input logic [1:0] s, input logic p);
        return {op, s, 1'b0, p};
    endfunction

    task automatic send(input logic [7:0] b1, input logic [7:0] b2, input int nbits);
        logic [7:0] rx;
        frame(idb(ADR), b1, b2, nbits, -1, rx);
    endtask

    task automatic expect_read(input logic [7:0] b1, input logic [7:0] expv, input string tag, input int hold_at);
        logic [7:0] rx;
        exp_q.push_back(expv);
        tag_q.push_back(tag);
        frame(idb(ADR), b1, 8'h00, 24, hold_at, rx);
        got_q.push_back(rx);
        tick(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic       r;
        logic [7:0] rx;
        logic [23:0] v;
        tick(5);
        rst = 1'b0;
        tick(5);
        // R1 boot values, R12 no drive without a chip-select fall
        chk("R1 wiper0 boot", {26'd0, wiper_pos[5:0]}, {26'd0, B0});
        chk("R1 wiper1 boot", {26'd0, wiper_pos[11:6]}, {26'd0, B1});
        chk("R12 so_oe after reset", {31'd0, so_oe}, 32'd0);
        v = {idb(ADR), ins(OP_WR_WIPER, 2'd0, 1'b0), 8'h05};
        for (int i = 0; i < 24; i++) spi_bit(v[23-i], r);
        tick(4);
        chk("R12 frame needs cs fall", {26'd0, wiper_pos[5:0]}, {26'd0, B0});
        cs_n = 1'b1;
        tick(6);
        chk("R12 so_oe while cs high", {31'd0, so_oe}, 32'd0);

        // R4 write and read of wiper
        send(ins(OP_WR_WIPER, 2'd0, 1'b0), 8'h0A, 24);
        chk("R4 wiper0 written", {26'd0, wiper_pos[5:0]}, 32'd10);
        expect_read(ins(OP_RD_WIPER, 2'd0, 1'b0), 8'h0A, "R4 read wiper0", -1);
        expect_read(ins(OP_RD_WIPER, 2'd0, 1'b1), {2'b00, B1}, "R4 read wiper1", -1);
        expect_read(ins(OP_RD_SLOT, 2'd0, 1'b0), {2'b00, B0}, "R1 slot0 boot", -1);
        expect_read(ins(OP_RD_SLOT, 2'd3, 1'b1), 8'h00, "R1 slot3 zero", -1);

        // R2 identification gating
        frame(idb(2'b01), ins(OP_WR_WIPER, 2'd0, 1'b0), 8'h33, 24, -1, rx);
        chk("R2 wrong address", {26'd0, wiper_pos[5:0]}, 32'd10);
        frame({4'b0110, 2'b00, ADR}, ins(OP_WR_WIPER, 2'd0, 1'b0), 8'h33, 24, -1, rx);
        chk("R2 wrong type", {26'd0, wiper_pos[5:0]}, 32'd10);
        frame({4'b0101, 2'b01, ADR}, ins(OP_WR_WIPER, 2'd0, 1'b0), 8'h33, 24, -1, rx);
        chk("R2 reserved bits set", {26'd0, wiper_pos[5:0]}, 32'd10);

        // R3 unknown opcode and bad bit 1
        send({4'b0011, 2'b00, 1'b0, 1'b0}, 8'h33, 24);
        chk("R3 unknown opcode", {26'd0, wiper_pos[5:0]}, 32'd10);
        send({4'b1010, 2'b00, 1'b1, 1'b0}, 8'h33, 24);
        chk("R3 bit1 set", {26'd0, wiper_pos[5:0]}, 32'd10);

        // R5 deferred slot write, R6 busy flag
        send(ins(OP_WR_SLOT, 2'd2, 1'b1), 8'h21, 24);
        expect_read(ins(OP_STATUS, 2'd0, 1'b0), 8'h01, "R6 busy after commit", -1);
        expect_read(ins(OP_RD_SLOT, 2'd2, 1'b1), 8'h21, "R5 slot write committed", -1);
        tick(NV + 50);
        expect_read(ins(OP_STATUS, 2'd0, 1'b0), 8'h00, "R6 busy cleared", -1);

        // R5 short frames change nothing
        send(ins(OP_WR_SLOT, 2'd1, 1'b0), 8'h15, 20);
        send(ins(OP_WR_WIPER, 2'd0, 1'b0), 8'h15, 20);
        chk("R5 short wiper write", {26'd0, wiper_pos[5:0]}, 32'd10);
        expect_read(ins(OP_STATUS, 2'd0, 1'b0), 8'h00, "R5 short frame no commit", -1);
        expect_read(ins(OP_RD_SLOT, 2'd1, 1'b0), 8'h00, "R5 short slot write", -1);

        // R6 second write while busy dropped
        send(ins(OP_WR_SLOT, 2'd3, 1'b0), 8'h07, 24);
        send(ins(OP_WR_SLOT, 2'd3, 1'b0), 8'h32, 24);
        expect_read(ins(OP_RD_SLOT, 2'd3, 1'b0), 8'h07, "R6 write during busy dropped", -1);
        tick(NV + 50);

        // R7 write protect
        wp_n = 1'b0;
        send(ins(OP_WR_SLOT, 2'd1, 1'b0), 8'h09, 24);
        send(ins(OP_WIPER_TO_SLOT, 2'd1, 1'b1), 8'h00, 16);
        wp_n = 1'b1;
        tick(20);
        expect_read(ins(OP_STATUS, 2'd0, 1'b0), 8'h00, "R7 no commit started", -1);
        expect_read(ins(OP_RD_SLOT, 2'd1, 1'b0), 8'h00, "R7 slot write blocked", -1);
        expect_read(ins(OP_RD_SLOT, 2'd1, 1'b1), 8'h00, "R7 copy out blocked", -1);

        // R8 single copies
        send(ins(OP_SLOT_TO_WIPER, 2'd2, 1'b1), 8'h00, 16);
        chk("R8 slot to wiper1", {26'd0, wiper_pos[11:6]}, 32'd33);
        chk("R8 wiper0 untouched", {26'd0, wiper_pos[5:0]}, 32'd10);
        send(ins(OP_WIPER_TO_SLOT, 2'd2, 1'b0), 8'h00, 16);
        expect_read(ins(OP_RD_SLOT, 2'd2, 1'b0), 8'h0A, "R8 wiper0 to slot2", -1);
        tick(NV + 50);

        // R9 both-channel copies
        send(ins(OP_BOTH_TO_SLOT, 2'd1, 1'b0), 8'h00, 16);
        tick(NV + 50);
        send(ins(OP_WR_WIPER, 2'd0, 1'b0), 8'h01, 24);
        send(ins(OP_WR_WIPER, 2'd0, 1'b1), 8'h02, 24);
        chk("R4 wiper1 written", {26'd0, wiper_pos[11:6]}, 32'd2);
        send(ins(OP_BOTH_TO_WIPER, 2'd1, 1'b0), 8'h00, 16);
        chk("R9 both to wiper ch0", {26'd0, wiper_pos[5:0]}, 32'd10);
        chk("R9 both to wiper ch1", {26'd0, wiper_pos[11:6]}, 32'd33);
        expect_read(ins(OP_RD_SLOT, 2'd1, 1'b1), 8'h21, "R9 both to slot ch1", -1);

        // R10 stepping with saturation
        send(ins(OP_WR_WIPER, 2'd0, 1'b0), 8'd61, 24);
        send(ins(OP_STEP, 2'd0, 1'b0), 8'b1111_1000, 24);
        chk("R10 step up saturate then down", {26'd0, wiper_pos[5:0]}, 32'd60);
        send(ins(OP_WR_WIPER, 2'd0, 1'b1), 8'd2, 24);
        send(ins(OP_STEP, 2'd0, 1'b1), 8'b0000_0000, 20);
        chk("R10 step down saturate", {26'd0, wiper_pos[11:6]}, 32'd0);
        chk("R10 other channel untouched", {26'd0, wiper_pos[5:0]}, 32'd60);

        // R11 hold inside instruction byte and inside reply byte
        frame(idb(ADR), ins(OP_WR_WIPER, 2'd0, 1'b0), 8'h2A, 24, 10, rx);
        chk("R11 write across pause", {26'd0, wiper_pos[5:0]}, 32'd42);
        expect_read(ins(OP_RD_SLOT, 2'd2, 1'b1), 8'h21, "R11 read across pause", 19);

        chk("R12 so_oe idle", {31'd0, so_oe}, 32'd0);
        tick(10);
        if (exp_q.size() != 0)
            chk("missing replies", exp_q.size(), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule